// File: doc/BRIEF.md
# System Clock Switch with Crystal Failure Fallback

This block picks the system clock from four sources: a multi-frequency RC oscillator, a 16 MHz RC oscillator, a crystal oscillator and the system output of a PLL. Each source arrives as a clock input with a ready signal. A change of source is glitch-free. A per-source enable chain on that source's falling edge first takes the old clock off the output and only then puts the new one on. A switch to a source that is not ready is held back until its ready signal comes up. The status field keeps showing the source actually driving the output until the handshake has finished.

A missing-edge monitor compares the crystal against the reference clock. If the crystal stops while the monitor is on, a sticky failure flag is set. The block then forces the selection to a backup RC oscillator, chosen by a control bit. It also raises a non-maskable interrupt and asserts a break output for the timers. Low-power wakeup inputs rewrite the selection. A standby exit always returns to the multi-frequency RC. A stop wakeup goes to whichever RC the wakeup-choice bit names. A small register port holds the requested source, the control bits, the status, the per-source ready interrupt flags and their enables.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the status source field reads 0 (multi-frequency RC) and the output clock follows that source. The control register reads 0, nmi and tim_break are low, and irq is low.
- R2: Source codes are 0 multi-frequency RC, 1 16 MHz RC, 2 crystal and 3 PLL. Writing a ready source code to the request field switches the output clock to that source while running. The status field then shows it.
- R3: A request for a source whose ready input is low leaves the output clock and the status field on the old source. The switch completes once that ready input rises.
- R4: At no time are two sources gated onto the output. The old source's gate is dropped on its own falling edge before the new source's gate is raised on the new source's falling edge.
- R5: A wake_stop pulse sets the request to 1 (16 MHz RC) when control bit 2 is 1, and to 0 when it is 0.
- R6: A wake_standby pulse sets the request to 0 (multi-frequency RC).
- R7: With control bit 3 set, MISS_LIMIT (8) consecutive reference cycles without a crystal edge set the failure flag (status bit 6, flag register bit 4). With bit 3 clear the flag never sets. The flag stays set until 1 is written to flag register bit 4.
- R8: While the failure flag is set, nmi and tim_break are high. A request for or a selection of the crystal is forced to the backup source: 0 when control bit 4 is 1, otherwise 1.
- R9: A rising ready input sets its flag bit (flag register bits 3:0, index = source code). Writing 1 to a bit clears it. irq is high exactly when a set flag has its enable bit set (enable register bits 3:0).
- R10: Register map. Address 0 is control: request in bits 1:0, stop-wakeup choice in bit 2, monitor enable in bit 3, backup choice in bit 4. Address 1 is status: current source in bits 1:0, synchronized ready inputs in bits 5:2 and the failure flag in bit 6. Address 2 holds the flags, written 1 to clear. Address 3 holds the enables. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_msi | input | 1 | Multi-frequency RC clock |
| clk_hsi | input | 1 | 16 MHz RC clock |
| clk_xtal | input | 1 | Crystal clock |
| clk_pll | input | 1 | PLL system output clock |
| rdy_msi | input | 1 | Multi-frequency RC ready |
| rdy_hsi | input | 1 | 16 MHz RC ready |
| rdy_xtal | input | 1 | Crystal ready |
| rdy_pll | input | 1 | PLL locked |
| wake_stop | input | 1 | Stop-mode wakeup pulse |
| wake_standby | input | 1 | Standby exit pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 7 | Register read data |
| sys_clk | output | 1 | Selected system clock |
| irq | output | 1 | Ready interrupt |
| nmi | output | 1 | Crystal failure non-maskable interrupt |
| tim_break | output | 1 | Break request to timers |

## Verification
The assertions check on every reference cycle that one source is selected and that at most one gate is open. They also check that a selection never moves to a source that was not ready, except when a failure forces it. Finally, they check that the failure flag only rises while the monitor is on, stays set until cleared, and always drives the selection off the crystal. Only the bench scenarios can show the output clock's actual frequency after each switch. The same holds for the deferred switch completing once ready rises, the wakeup rewrites, the fallback to the chosen backup when the crystal clock is stopped, and the interrupt masking.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NSRC   = 4;
  localparam int REG_WW = 5;
  localparam int REG_RW = 7;

  typedef enum logic [1:0] {
    SRC_MSI  = 2'd0,
    SRC_HSI  = 2'd1,
    SRC_XTAL = 2'd2,
    SRC_PLL  = 2'd3
  } src_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_FLAG = 2'd2;
  localparam logic [1:0] ADR_IEN  = 2'd3;
endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sysclk_xtal_mon.sv
module sysclk_xtal_mon #(
  parameter int MISS_LIMIT = 8,
  parameter int STAGES     = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic rst_ref_n,
  input  logic clk_xtal,
  input  logic en,
  input  logic clr,
  output logic fail
);
  localparam int CW = $clog2(MISS_LIMIT + 1);

  logic          tog, tog_s, tog_q, edge_seen;
  logic [CW-1:0] cnt, cnt_d;
  logic          fail_d;

  // toggle in the crystal domain, so every crystal edge becomes a level change
  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  sysclk_sync #(.W(1), .STAGES(STAGES)) u_tog_sync (
    .clk(clk_ref), .rst_n(rst_ref_n), .d(tog), .q(tog_s)
  );

  assign edge_seen = tog_s ^ tog_q;

  always_comb begin
    cnt_d  = cnt;
    fail_d = fail;
    if (!en || edge_seen)                 cnt_d = '0;
    else if (cnt != CW'(MISS_LIMIT))      cnt_d = cnt + 1'b1;
    if (en && !edge_seen && cnt == CW'(MISS_LIMIT - 1)) fail_d = 1'b1;
    else if (clr)                         fail_d = 1'b0;
  end

  always_ff @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      tog_q <= 1'b0;
      cnt   <= '0;
      fail  <= 1'b0;
    end else begin
      tog_q <= tog_s;
      cnt   <= cnt_d;
      fail  <= fail_d;
    end
  end
endmodule

// File: rtl/sysclk_gf_mux.sv
module sysclk_gf_mux
  import sysclk_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic            rst_n,
  input  logic [NSRC-1:0] clk_src,
  input  logic [NSRC-1:0] sel_oh,
  input  logic [NSRC-1:0] kill,
  output logic [NSRC-1:0] gate_en,
  output logic            clk_out
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [STAGES-1:0] sh;
    logic              arst_n;
    logic              d;

    // a killed chain is cleared at once: a dead clock cannot drop its own gate
    assign arst_n = rst_n & ~kill[i];
    // raise only once every other gate has closed
    assign d = sel_oh[i] & ~(|(gate_en & ~(NSRC'(1) << i)));

    always_ff @(negedge clk_src[i] or negedge arst_n) begin
      if (!arst_n) sh <= {STAGES{1'(i == 0)}};
      else         sh <= {sh[STAGES-2:0], d};
    end

    assign gate_en[i] = sh[STAGES-1];
  end

  assign clk_out = |(clk_src & gate_en);
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   rdy_s,
  input  logic [NSRC-1:0]   act_s,
  input  logic              css_fail,
  input  logic              wake_stop,
  input  logic              wake_standby,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [REG_WW-1:0] reg_wdata,
  output logic [REG_RW-1:0] reg_rdata,
  output logic [NSRC-1:0]   sel_oh,
  output src_e              active_src,
  output logic              css_en,
  output logic              css_clr,
  output logic              irq
);
  src_e            sw_req, req_d, act_d, cur_src, cur_d, backup;
  logic            stop_hsi, fb_msi;
  logic [NSRC-1:0] rdy_q, rdy_flag, flag_d, rdy_ie;
  logic            wr_ctrl, wr_flag, wr_ien;

  assign wr_ctrl = reg_we && (reg_addr == ADR_CTRL);
  assign wr_flag = reg_we && (reg_addr == ADR_FLAG);
  assign wr_ien  = reg_we && (reg_addr == ADR_IEN);
  assign css_clr = wr_flag && reg_wdata[4];
  assign backup  = fb_msi ? SRC_MSI : SRC_HSI;

  // request: register write < stop wakeup < standby exit < failure override
  always_comb begin
    req_d = sw_req;
    if (wr_ctrl)      req_d = src_e'(reg_wdata[1:0]);
    if (wake_stop)    req_d = stop_hsi ? SRC_HSI : SRC_MSI;
    if (wake_standby) req_d = SRC_MSI;
    if (css_fail && req_d == SRC_XTAL) req_d = backup;
  end

  // selection follows the request only once the target is ready
  always_comb begin
    act_d = active_src;
    if (css_fail && active_src == SRC_XTAL)
      act_d = backup;
    else if (sw_req != active_src && rdy_s[sw_req] &&
             !(css_fail && sw_req == SRC_XTAL))
      act_d = sw_req;
  end

  always_comb begin
    cur_d = cur_src;
    for (int k = 0; k < NSRC; k++)
      if (act_s[k]) cur_d = src_e'(2'(k));
  end

  always_comb begin
    flag_d = rdy_flag;
    if (wr_flag) flag_d = flag_d & ~reg_wdata[NSRC-1:0];
    flag_d = flag_d | (rdy_s & ~rdy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_req     <= SRC_MSI;
      active_src <= SRC_MSI;
      cur_src    <= SRC_MSI;
      stop_hsi   <= 1'b0;
      css_en     <= 1'b0;
      fb_msi     <= 1'b0;
      rdy_q      <= '0;
      rdy_flag   <= '0;
      rdy_ie     <= '0;
    end else begin
      sw_req     <= req_d;
      active_src <= act_d;
      cur_src    <= cur_d;
      rdy_q      <= rdy_s;
      rdy_flag   <= flag_d;
      if (wr_ctrl) begin
        stop_hsi <= reg_wdata[2];
        css_en   <= reg_wdata[3];
        fb_msi   <= reg_wdata[4];
      end
      if (wr_ien) rdy_ie <= reg_wdata[NSRC-1:0];
    end
  end

  assign sel_oh = NSRC'(1) << active_src;
  assign irq    = |(rdy_flag & rdy_ie);

  always_comb begin
    unique case (reg_addr)
      ADR_CTRL: reg_rdata = {2'b00, fb_msi, css_en, stop_hsi, sw_req};
      ADR_STAT: reg_rdata = {css_fail, rdy_s, cur_src};
      ADR_FLAG: reg_rdata = {2'b00, css_fail, rdy_flag};
      default:  reg_rdata = {3'b000, rdy_ie};
    endcase
  end
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_pkg::*;
#(
  parameter int MISS_LIMIT = 8,
  parameter int STAGES     = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              clk_msi,
  input  logic              clk_hsi,
  input  logic              clk_xtal,
  input  logic              clk_pll,
  input  logic              rdy_msi,
  input  logic              rdy_hsi,
  input  logic              rdy_xtal,
  input  logic              rdy_pll,
  input  logic              wake_stop,
  input  logic              wake_standby,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [REG_WW-1:0] reg_wdata,
  output logic [REG_RW-1:0] reg_rdata,
  output logic              sys_clk,
  output logic              irq,
  output logic              nmi,
  output logic              tim_break
);
  logic [1:0]      rst_sh;
  logic            rst_ref_n;
  logic [NSRC-1:0] clk_vec, rdy_vec, rdy_s, gate_en, act_s, sel_oh, kill;
  logic            css_fail, css_en, css_clr;
  src_e            active_src;

  // reset asserted asynchronously, released on the reference clock
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ref_n = rst_sh[1];

  assign clk_vec = {clk_pll, clk_xtal, clk_hsi, clk_msi};
  assign rdy_vec = {rdy_pll, rdy_xtal, rdy_hsi, rdy_msi};
  assign kill    = NSRC'(css_fail) << SRC_XTAL;

  sysclk_sync #(.W(NSRC), .STAGES(STAGES)) u_rdy_sync (
    .clk(clk_ref), .rst_n(rst_ref_n), .d(rdy_vec), .q(rdy_s)
  );

  sysclk_sync #(.W(NSRC), .STAGES(STAGES)) u_act_sync (
    .clk(clk_ref), .rst_n(rst_ref_n), .d(gate_en), .q(act_s)
  );

  sysclk_xtal_mon #(.MISS_LIMIT(MISS_LIMIT), .STAGES(STAGES)) u_mon (
    .clk_ref(clk_ref), .rst_n(rst_n), .rst_ref_n(rst_ref_n),
    .clk_xtal(clk_xtal), .en(css_en), .clr(css_clr), .fail(css_fail)
  );

  sysclk_ctrl u_ctrl (
    .clk(clk_ref), .rst_n(rst_ref_n), .rdy_s(rdy_s), .act_s(act_s),
    .css_fail(css_fail), .wake_stop(wake_stop), .wake_standby(wake_standby),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sel_oh(sel_oh), .active_src(active_src),
    .css_en(css_en), .css_clr(css_clr), .irq(irq)
  );

  sysclk_gf_mux #(.STAGES(STAGES)) u_mux (
    .rst_n(rst_n), .clk_src(clk_vec), .sel_oh(sel_oh), .kill(kill),
    .gate_en(gate_en), .clk_out(sys_clk)
  );

  assign nmi       = css_fail;
  assign tim_break = css_fail;
endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk
  import sysclk_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] sel_oh,
  input logic [NSRC-1:0] gate_en,
  input logic [NSRC-1:0] rdy_s,
  input src_e            active_src,
  input logic            css_fail,
  input logic            css_en,
  input logic            css_clr
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_oh) == 1); // R4

  AST_GATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_en)); // R4

  AST_SWITCH_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (active_src != $past(active_src)) && !$past(css_fail)
      |-> |($past(rdy_s) & (4'b0001 << active_src))); // R3

  AST_FAIL_LEAVES_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
    css_fail && active_src == SRC_XTAL |=> active_src != SRC_XTAL); // R8

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    css_fail && !css_clr |=> css_fail); // R7

  AST_FAIL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(css_fail) |-> $past(css_en)); // R7
endmodule

bind sysclk_switch sysclk_switch_chk u_chk (
  .clk(clk_ref), .rst_n(rst_ref_n), .sel_oh(sel_oh), .gate_en(gate_en),
  .rdy_s(rdy_s), .active_src(active_src), .css_fail(css_fail),
  .css_en(css_en), .css_clr(css_clr)
);

// File: tb/sysclk_switch_tb.sv
module sysclk_switch_tb;
  logic clk_ref = 1'b0, rst_n = 1'b0;
  logic clk_msi = 1'b0, clk_hsi = 1'b0, clk_xtal = 1'b0, clk_pll = 1'b0;
  logic rdy_msi = 1'b1, rdy_hsi = 1'b1, rdy_xtal = 1'b1, rdy_pll = 1'b1;
  logic wake_stop = 1'b0, wake_standby = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [4:0] reg_wdata = 5'd0;
  logic [6:0] reg_rdata;
  logic sys_clk, irq, nmi, tim_break;
  logic xtal_run = 1'b1, cnt_on = 1'b0;
  int   edges = 0, errors = 0, checks = 0;
  bit   done = 1'b0;

  always #10 clk_ref  = ~clk_ref;
  always #7  clk_msi  = ~clk_msi;
  always #8  clk_hsi  = ~clk_hsi;
  always #28 clk_xtal = xtal_run ? ~clk_xtal : clk_xtal;
  always #5  clk_pll  = ~clk_pll;

  always @(posedge sys_clk) if (cnt_on) edges++;

  sysclk_switch u_dut (.*);

  function automatic int src_period(input int s);
    case (s)
      0: return 14;
      1: return 16;
      2: return 56;
      default: return 10;
    endcase
  endfunction

  function automatic int exp_edges(input int s);
    return 800 / src_period(s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk_ref); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_ref); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [6:0] d);
    @(negedge clk_ref); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic chk_src(input int exp, input string req);
    logic [6:0] d;
    rd(2'd1, d);
    chk(int'(d[1:0]) == exp, req, int'(d[1:0]), exp);
  endtask

  task automatic chk_clk(input int s, input string req);
    edges = 0; cnt_on = 1'b1; #800; cnt_on = 1'b0;
    chk(edges >= exp_edges(s) - 2 && edges <= exp_edges(s) + 2, req, edges, exp_edges(s));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [6:0] d;
    int cur;
    void'($urandom(32'd4242));
    wait_ref(3); rst_n = 1'b1; wait_ref(6);

    // R1 reset state
    chk_src(0, "R1 status source");
    rd(2'd0, d); chk(d == 7'd0, "R1 control", int'(d), 0);
    chk(nmi == 1'b0 && tim_break == 1'b0, "R1 nmi/break", int'(nmi), 0);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk_clk(0, "R1 output clock");

    // R2 switch to ready PLL
    wr(2'd0, 5'h03); wait_ref(30);
    chk_src(3, "R2 status after switch");
    chk_clk(3, "R2 output clock");

    // R3 deferred switch to non-ready 16 MHz RC
    rdy_hsi = 1'b0; wait_ref(4);
    wr(2'd0, 5'h01); wait_ref(30);
    chk_src(3, "R3 status held");
    chk_clk(3, "R3 output clock held");
    rdy_hsi = 1'b1; wait_ref(30);
    chk_src(1, "R3 status after ready");
    chk_clk(1, "R3 output clock after ready");

    // R9 ready flags and irq masking
    wr(2'd2, 5'h0F); wait_ref(2);
    rd(2'd2, d); chk(d[3:0] == 4'd0, "R9 flags cleared", int'(d[3:0]), 0);
    wr(2'd3, 5'h08);
    rdy_pll = 1'b0; wait_ref(6); rdy_pll = 1'b1; wait_ref(6);
    rd(2'd2, d); chk(d[3] == 1'b1, "R9 pll flag set", int'(d[3]), 1);
    chk(irq == 1'b1, "R9 irq enabled", int'(irq), 1);
    wr(2'd2, 5'h08); wait_ref(2);
    chk(irq == 1'b0, "R9 irq after clear", int'(irq), 0);
    rdy_xtal = 1'b0; wait_ref(6); rdy_xtal = 1'b1; wait_ref(6);
    rd(2'd2, d); chk(d[2] == 1'b1, "R9 xtal flag set", int'(d[2]), 1);
    chk(irq == 1'b0, "R9 masked flag no irq", int'(irq), 0);
    wr(2'd2, 5'h0F);

    // R5 stop wakeup, R6 standby exit, R10 control readback
    wr(2'd0, 5'h07); wait_ref(30);
    rd(2'd0, d); chk(d[2:0] == 3'd7, "R10 control readback", int'(d), 7);
    chk_src(3, "R5 start on pll");
    @(negedge clk_ref); wake_stop = 1'b1; @(negedge clk_ref); wake_stop = 1'b0;
    wait_ref(30); chk_src(1, "R5 stop wake to 16 MHz RC");
    wr(2'd0, 5'h01); wait_ref(4);
    @(negedge clk_ref); wake_stop = 1'b1; @(negedge clk_ref); wake_stop = 1'b0;
    wait_ref(30); chk_src(0, "R5 stop wake to multi RC");
    wr(2'd0, 5'h01); wait_ref(30); chk_src(1, "R6 start on 16 MHz RC");
    @(negedge clk_ref); wake_standby = 1'b1; @(negedge clk_ref); wake_standby = 1'b0;
    wait_ref(30); chk_src(0, "R6 standby exit to multi RC");

    // R7/R8 crystal failure, backup 16 MHz RC
    wr(2'd0, 5'h0A); wait_ref(40);
    chk_src(2, "R8 on crystal");
    chk(nmi == 1'b0, "R7 no fail while running", int'(nmi), 0);
    xtal_run = 1'b0; wait_ref(40);
    chk(nmi == 1'b1 && tim_break == 1'b1, "R8 nmi and break", int'(nmi), 1);
    rd(2'd1, d); chk(d[6] == 1'b1, "R7 status fail flag", int'(d[6]), 1);
    chk(int'(d[1:0]) == 1, "R8 fallback to 16 MHz RC", int'(d[1:0]), 1);
    rd(2'd0, d); chk(d[1:0] == 2'd1, "R8 request overridden", int'(d[1:0]), 1);
    chk_clk(1, "R8 output clock on backup");
    wait_ref(20); chk(nmi == 1'b1, "R7 flag sticky", int'(nmi), 1);
    xtal_run = 1'b1; wait_ref(10);
    wr(2'd2, 5'h10); wait_ref(20);
    chk(nmi == 1'b0, "R7 flag cleared", int'(nmi), 0);

    // R8 backup multi RC, crystal request ignored while failed
    wr(2'd0, 5'h1A); wait_ref(40); chk_src(2, "R8 back on crystal");
    xtal_run = 1'b0; wait_ref(40);
    chk_src(0, "R8 fallback to multi RC");
    wr(2'd0, 5'h1A); wait_ref(30);
    chk_src(0, "R8 crystal request ignored");
    xtal_run = 1'b1; wait_ref(10);
    wr(2'd2, 5'h10); wr(2'd0, 5'h00); wait_ref(10);

    // R7 monitor disabled: no failure
    wr(2'd0, 5'h02); wait_ref(40);
    xtal_run = 1'b0; wait_ref(40);
    chk(nmi == 1'b0, "R7 disabled monitor", int'(nmi), 0);
    chk_src(2, "R7 no fallback when disabled");
    xtal_run = 1'b1; wait_ref(10);

    // R2/R3 random switching
    cur = 2;
    for (int it = 0; it < 16; it++) begin
      int tgt;
      bit rdy;
      tgt = int'($urandom % 4);
      rdy = (tgt == cur || tgt == 0 || tgt == 2) ? 1'b1 : 1'(($urandom % 2));
      if (tgt == 1) rdy_hsi = rdy;
      if (tgt == 3) rdy_pll = rdy;
      wait_ref(4);
      wr(2'd0, 5'(tgt)); wait_ref(30);
      if (rdy) begin
        chk_src(tgt, "R2 random switch");
        cur = tgt;
      end else begin
        chk_src(cur, "R3 random hold");
        if (tgt == 1) rdy_hsi = 1'b1;
        if (tgt == 3) rdy_pll = 1'b1;
        wait_ref(30);
        chk_src(tgt, "R3 random completion");
        cur = tgt;
      end
      if (it % 4 == 0) chk_clk(cur, "R2 random clock");
    end

    finish_run();
  end
endmodule